// File: doc/BRIEF.md
# I2C Master Condition Sequencer

This block sits between a host with a small parallel register port and an open-drain I2C bus. It creates the bus conditions a master needs: START, repeated START and STOP. The host writes one control register with a start request, a stop request, an interrupt enable and a mode bit, and reads either that register or a status register. The block does not shift data bytes. A separate shifter reports each finished byte on `byte_done`, and a separate address matcher reports on `slave_addressed` that the block has been addressed as a slave.

A bus monitor synchronises SCL and SDA. It marks the bus busy on a START, marks it free on a STOP, and counts the idle time since the last STOP. A START is issued only once that count reaches the programmed bus-free time. Each completed step sets a serial-interrupt flag and loads a status code. While that flag is set, an SCL low phase is held low until the host writes the control register. The bus-free time and the SCL half-period are cycle counts sampled from configuration inputs while reset is held.

The state machine has these states:
- IDLE (status F8h).
- WAIT: waits for a free bus.
- START_HOLD: SDA low, SCL released.
- START_CLK: SCL pulled low.
- OWN: the block owns the bus, with both lines low.
- RS_REL: SDA released, SCL low.
- RS_HIGH: both lines released.
- STOP_LOW: both lines low.
- STOP_HIGH: SCL released.
- STOP_REL: SDA released, waiting for the STOP to be seen.

Its transitions are:
- IDLE→WAIT on a start request.
- WAIT→START_HOLD when the bus is free, the bus-free time has elapsed and no slave-role STOP is pending.
- START_HOLD→START_CLK→OWN, each after one half-period.
- OWN→STOP_LOW on a stop request while the flag is clear.
- OWN→RS_REL on a start request after at least one byte.
- RS_REL→RS_HIGH→START_HOLD, each after one half-period.
- STOP_LOW→STOP_HIGH→STOP_REL, each after one half-period.
- STOP_REL→WAIT when a start request is still set, otherwise STOP_REL→IDLE. Both happen once the STOP is seen on the bus.

Top module: `i2c_cond_seq`

## Requirements
- R1: After reset the control register reads 00h, the status reads F8h, neither line is pulled and `irq` is low.
- R2: Control register bits: bit 6 enable, bit 5 start request, bit 4 stop request, bit 3 interrupt flag (read only; writing 1 does not set it), bit 0 mode (stored and read back). Bits 7, 2 and 1 read as zero.
- R3: A start request on a free, idle bus pulls SDA low while SCL is released, then pulls SCL low. The status becomes 08h, the flag sets and the start request clears.
- R4: A start request made while the bus is busy waits for a STOP on the bus. The START then comes no sooner than the bus-free time after that STOP.
- R5: A start request made while `slave_addressed` is high waits for a STOP on the bus and then the bus-free time, even if the bus looked idle.
- R6: A start request in master mode after at least one byte produces a repeated START with status 10h. Before any byte it produces no condition.
- R7: A stop request in master mode produces SDA rising while SCL is released. The stop request clears once the STOP is seen, the status becomes E0h and the flag sets.
- R8: Start and stop requested together in master mode produce a STOP and then a START no sooner than the bus-free time later, ending with status 08h.
- R9: The flag is set only together with a status other than F8h. Any control write clears it, and a write while idle returns the status to F8h.
- R10: `irq` is high only when both the flag and the enable bit are set.
- R11: While the flag is set, SCL is held low once it has been seen low, and is released only when the flag clears. SCL that is high is not pulled.
- R12: `byte_done` in master mode with the flag clear sets the flag with status 28h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; configuration is sampled while it is low |
| cfg_tbuf | input | CNT_W | Bus-free time in cycles |
| cfg_half | input | CNT_W | SCL half-period in cycles |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_sel | input | 1 | Read select: 0 control, 1 status |
| rd_data | output | 8 | Selected register value |
| slave_addressed | input | 1 | High while the block is an addressed slave |
| byte_done | input | 1 | One-cycle pulse when a byte has been transferred |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| irq | output | 1 | Interrupt request |

## Verification
Directed patterns exercise the main paths one at a time:
- a start request on an idle bus;
- a start request behind another master's START;
- a start request behind the slave role;
- a start request before and after a byte in master mode, which separates a repeated START from no action;
- a combined start and stop request, which separates STOP-then-START from a lone condition.

A bus monitor in the bench measures the gap from each STOP to the next plain START. This exposes a timer that starts counting too early or ignores the busy flag.

A seeded random mix of byte, repeated-start and stop-then-start steps in random order and with random delays catches state left behind from one step to the next. The stretch test pulls SCL low from outside while the flag is set. This separates holding a low phase from pulling a line that is high.

// File: rtl/cs_pkg.sv
package cs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_WAIT,
        ST_START_HOLD,
        ST_START_CLK,
        ST_OWN,
        ST_RS_REL,
        ST_RS_HIGH,
        ST_STOP_LOW,
        ST_STOP_HIGH,
        ST_STOP_REL
    } seq_state_t;

    localparam logic [7:0] CODE_IDLE   = 8'hF8;
    localparam logic [7:0] CODE_START  = 8'h08;
    localparam logic [7:0] CODE_RSTART = 8'h10;
    localparam logic [7:0] CODE_BYTE   = 8'h28;
    localparam logic [7:0] CODE_STOP   = 8'hE0;

    localparam int B_EN   = 6;
    localparam int B_STA  = 5;
    localparam int B_STO  = 4;
    localparam int B_SI   = 3;
    localparam int B_MODE = 0;

endpackage

// File: rtl/cs_bus_monitor.sv
// Synchronises the bus lines, tracks busy/free and counts idle cycles.
module cs_bus_monitor #(
    parameter int CNT_W  = 16,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    input  logic [CNT_W-1:0] tbuf_len,
    output logic             scl_s,
    output logic             stop_det,
    output logic             bus_busy,
    output logic             free_ok
);

    localparam int TOP = SYNC_N - 1;

    logic [SYNC_N-1:0] scl_sync, sda_sync;
    logic              scl_prev, sda_prev;
    logic              start_det;
    logic [CNT_W-1:0]  free_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync <= '1;
            sda_sync <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sync <= {scl_sync[SYNC_N-2:0], scl_i};
            sda_sync <= {sda_sync[SYNC_N-2:0], sda_i};
            scl_prev <= scl_sync[TOP];
            sda_prev <= sda_sync[TOP];
        end
    end

    assign scl_s     = scl_sync[TOP];
    assign start_det = scl_prev & scl_sync[TOP] & sda_prev & ~sda_sync[TOP];
    assign stop_det  = scl_prev & scl_sync[TOP] & ~sda_prev & sda_sync[TOP];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bus_busy <= 1'b0;
            free_cnt <= '0;
        end else begin
            if (start_det)     bus_busy <= 1'b1;
            else if (stop_det) bus_busy <= 1'b0;

            if (bus_busy || start_det || stop_det) free_cnt <= '0;
            else if (free_cnt < tbuf_len)          free_cnt <= free_cnt + 1'b1;
        end
    end

    assign free_ok = !bus_busy && (free_cnt >= tbuf_len);

endmodule

// File: rtl/cs_phase_timer.sv
// Down counter for the SCL half-period of each timed state.
module cs_phase_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= len;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/cs_sequencer.sv
// Control/status registers and the condition state machine.
module cs_sequencer
    import cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       rd_sel,
    output logic [7:0] rd_data,
    input  logic       slave_addressed,
    input  logic       byte_done,
    input  logic       scl_s,
    input  logic       stop_det,
    input  logic       bus_busy,
    input  logic       free_ok,
    input  logic       tmr_expired,
    output logic       tmr_load,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic       irq,
    output logic       si_o,
    output logic       rs_o
);

    seq_state_t st_q, st_d;

    logic       sta_q, sto_q, si_q, en_q, mode_q;
    logic [7:0] status_q;
    logic       bytes_seen_q, rs_q, pend_q, stretch_q;
    logic       fsm_scl, fsm_sda;
    logic       ignored_unused;

    assign ignored_unused = ^{wr_data[7], wr_data[B_SI], wr_data[2:1]};

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:       if (sta_q) st_d = ST_WAIT;
            ST_WAIT:       if (!pend_q && !bus_busy && free_ok) st_d = ST_START_HOLD;
            ST_START_HOLD: if (tmr_expired) st_d = ST_START_CLK;
            ST_START_CLK:  if (tmr_expired) st_d = ST_OWN;
            ST_OWN: begin
                if (!si_q) begin
                    if (sto_q)                      st_d = ST_STOP_LOW;
                    else if (sta_q && bytes_seen_q) st_d = ST_RS_REL;
                end
            end
            ST_RS_REL:     if (tmr_expired) st_d = ST_RS_HIGH;
            ST_RS_HIGH:    if (tmr_expired) st_d = ST_START_HOLD;
            ST_STOP_LOW:   if (tmr_expired) st_d = ST_STOP_HIGH;
            ST_STOP_HIGH:  if (tmr_expired) st_d = ST_STOP_REL;
            ST_STOP_REL:   if (stop_det) st_d = sta_q ? ST_WAIT : ST_IDLE;
            default:       st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    assign tmr_load = (st_d != st_q);

    // line outputs per state
    always_comb begin
        fsm_scl = 1'b0;
        fsm_sda = 1'b0;
        unique case (st_q)
            ST_START_HOLD: fsm_sda = 1'b1;
            ST_START_CLK:  begin fsm_sda = 1'b1; fsm_scl = 1'b1; end
            ST_OWN:        begin fsm_sda = 1'b1; fsm_scl = 1'b1; end
            ST_RS_REL:     fsm_scl = 1'b1;
            ST_STOP_LOW:   begin fsm_sda = 1'b1; fsm_scl = 1'b1; end
            ST_STOP_HIGH:  fsm_sda = 1'b1;
            default:       ;
        endcase
    end

    // register file, flag and status updates
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sta_q        <= 1'b0;
            sto_q        <= 1'b0;
            si_q         <= 1'b0;
            en_q         <= 1'b0;
            mode_q       <= 1'b0;
            status_q     <= CODE_IDLE;
            bytes_seen_q <= 1'b0;
            rs_q         <= 1'b0;
            pend_q       <= 1'b0;
            stretch_q    <= 1'b0;
        end else begin
            if (wr_en) begin
                sta_q  <= wr_data[B_STA];
                sto_q  <= wr_data[B_STO];
                en_q   <= wr_data[B_EN];
                mode_q <= wr_data[B_MODE];
                si_q   <= 1'b0;
                if (st_q == ST_IDLE) status_q <= CODE_IDLE;
            end

            if (st_q == ST_WAIT && st_d == ST_START_HOLD) sta_q <= 1'b0;

            if (st_q == ST_OWN && st_d == ST_RS_REL) begin
                sta_q <= 1'b0;
                rs_q  <= 1'b1;
            end

            if (st_q == ST_START_CLK && st_d == ST_OWN) begin
                si_q         <= 1'b1;
                status_q     <= rs_q ? CODE_RSTART : CODE_START;
                rs_q         <= 1'b0;
                bytes_seen_q <= 1'b0;
            end

            if (st_q == ST_OWN && st_d == ST_OWN && !si_q && byte_done) begin
                si_q         <= 1'b1;
                status_q     <= CODE_BYTE;
                bytes_seen_q <= 1'b1;
            end

            if (st_q == ST_STOP_REL && stop_det) begin
                sto_q <= 1'b0;
                if (!sta_q) begin
                    si_q     <= 1'b1;
                    status_q <= CODE_STOP;
                end
            end

            if (st_q == ST_IDLE && st_d == ST_WAIT) pend_q <= slave_addressed;
            else if (stop_det)                     pend_q <= 1'b0;

            stretch_q <= si_q & (~scl_s | stretch_q);
        end
    end

    assign rd_data = rd_sel ? status_q
                            : {1'b0, en_q, sta_q, sto_q, si_q, 2'b00, mode_q};
    assign scl_oe  = fsm_scl | stretch_q;
    assign sda_oe  = fsm_sda;
    assign irq     = si_q & en_q;
    assign si_o    = si_q;
    assign rs_o    = rs_q;

endmodule

// File: rtl/i2c_cond_seq.sv
module i2c_cond_seq #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cfg_tbuf,
    input  logic [CNT_W-1:0] cfg_half,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             rd_sel,
    output logic [7:0]       rd_data,
    input  logic             slave_addressed,
    input  logic             byte_done,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             scl_oe,
    output logic             sda_oe,
    output logic             irq
);

    logic [CNT_W-1:0] tbuf_q, half_q;
    logic scl_s, stop_det, bus_busy, free_ok;
    logic tmr_load, tmr_expired, si_flag, rs_flag;

    // timing configuration captured while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbuf_q <= cfg_tbuf;
            half_q <= cfg_half;
        end
    end

    cs_bus_monitor #(.CNT_W(CNT_W), .SYNC_N(2)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .tbuf_len(tbuf_q), .scl_s(scl_s), .stop_det(stop_det),
        .bus_busy(bus_busy), .free_ok(free_ok)
    );

    cs_phase_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .len(half_q),
        .expired(tmr_expired)
    );

    cs_sequencer u_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data),
        .slave_addressed(slave_addressed), .byte_done(byte_done),
        .scl_s(scl_s), .stop_det(stop_det), .bus_busy(bus_busy),
        .free_ok(free_ok), .tmr_expired(tmr_expired), .tmr_load(tmr_load),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq),
        .si_o(si_flag), .rs_o(rs_flag)
    );

endmodule

// File: rtl/cs_seq_checker.sv
module cs_seq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic       rd_sel,
    input logic [7:0] rd_data,
    input logic       bus_busy,
    input logic       free_ok,
    input logic       si_flag,
    input logic       rs_flag
);

    // R3: SDA is pulled for a START only while SCL is released
    a_r3_sda_before_scl: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_oe);

    // R4: a plain START only on a free bus after the bus-free time
    a_r4_start_needs_free: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) && !rs_flag) |-> (!bus_busy && free_ok));

    // R7: SDA released with SCL released was preceded by SCL released (STOP)
    a_r7_stop_edge: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe) && !scl_oe) |-> $past(!scl_oe));

    // R9: flag set only with a non-idle status code
    a_r9_si_code: assert property (@(posedge clk) disable iff (!rst_n)
        (si_flag && rd_sel) |-> (rd_data != 8'hF8));

    // R11: a held SCL stays held while the flag stays set
    a_r11_stretch_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (si_flag && $past(si_flag) && $past(scl_oe)) |-> scl_oe);

endmodule

bind i2c_cond_seq cs_seq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .rd_sel(rd_sel), .rd_data(rd_data), .bus_busy(bus_busy),
    .free_ok(free_ok), .si_flag(si_flag), .rs_flag(rs_flag)
);

// File: tb/i2c_cond_seq_bench.sv
module i2c_cond_seq_bench;

    localparam int CW   = 16;
    localparam int TBUF = 20;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_sel = 1'b0;
    logic       slave_addressed = 1'b0;
    logic       byte_done = 1'b0;
    logic       ext_scl = 1'b0;
    logic       ext_sda = 1'b0;
    wire  [7:0] rd_data;
    wire        scl_oe, sda_oe, irq;
    wire        scl_line = !(scl_oe || ext_scl);
    wire        sda_line = !(sda_oe || ext_sda);

    int  total = 0;
    int  bad = 0;
    bit  finished = 0;
    int  cyc = 0;
    int  starts = 0;
    int  stops = 0;
    int  last_stop = 0;
    bit  tb_busy = 0;
    bit  seen_stop = 0;
    logic prev_scl = 1'b1;
    logic prev_sda = 1'b1;

    i2c_cond_seq #(.CNT_W(CW)) u_i2c_cond_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_tbuf(CW'(TBUF)), .cfg_half(CW'(HALF)),
        .wr_en(wr_en), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .slave_addressed(slave_addressed), .byte_done(byte_done),
        .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bus monitor: condition counting and bus-free gap measurement (R4, R8)
    always @(negedge clk) begin
        cyc++;
        if (rst_n && prev_scl && scl_line && prev_sda && !sda_line) begin
            starts++;
            if (sda_oe && !tb_busy && seen_stop)
                chk("R4 gap from STOP to START >= tbuf", 32'((cyc - last_stop) >= TBUF), 1);
            tb_busy = 1;
        end
        if (rst_n && prev_scl && scl_line && !prev_sda && sda_line) begin
            stops++;
            tb_busy = 0;
            last_stop = cyc;
            seen_stop = 1;
        end
        prev_scl = scl_line;
        prev_sda = sda_line;
    end

    function automatic logic [7:0] exp_code(input int op);
        case (op)
            0: return 8'h10;
            1: return 8'h08;
            default: return 8'h28;
        endcase
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        rd_sel = sel;
        #1;
        v = rd_data;
    endtask

    task automatic pulse_byte();
        @(negedge clk);
        byte_done = 1'b1;
        @(negedge clk);
        byte_done = 1'b0;
        #1;
    endtask

    task automatic wait_irq(input string req);
        bit got = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            #1;
            if (irq) begin
                got = 1;
                break;
            end
        end
        chk(req, 32'(got), 1);
    endtask

    task automatic stop_and_clear();
        host_write(8'h50);
        wait_irq("R7 irq after stop");
        host_write(8'h40);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int s0, p0;
        void'($urandom(32'd1234));
        tick(5);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        rd(0, v); chk("R1 control after reset", v, 8'h00);
        rd(1, v); chk("R1 status after reset", v, 8'hF8);
        chk("R1 lines released", {scl_oe, sda_oe, irq}, 3'b000);
        tick(TBUF + 5);

        // R2 reserved bits read zero, flag not writable, mode stored
        host_write(8'hCF);
        rd(0, v); chk("R2 control readback", v, 8'h41);
        chk("R10 no irq without flag", irq, 0);

        // R3 start on idle bus
        s0 = starts;
        host_write(8'h60);
        wait_irq("R3 irq after start");
        rd(1, v); chk("R3 status after start", v, 8'h08);
        rd(0, v); chk("R3 start request cleared, flag set", v, 8'h48);
        chk("R3 start seen on bus", starts - s0, 1);
        chk("R3 both lines held", {scl_oe, sda_oe}, 2'b11);

        // R6 start request before any byte does nothing
        s0 = starts;
        host_write(8'h60);
        tick(60);
        chk("R6 no condition before a byte", starts - s0, 0);
        chk("R9 write cleared flag", irq, 0);
        rd(1, v); chk("R6 status unchanged", v, 8'h08);
        host_write(8'h40);

        // R12 byte event
        pulse_byte();
        tick(1);
        chk("R12 irq after byte", irq, 1);
        rd(1, v); chk("R12 byte status", v, 8'h28);

        // R6 repeated start after a byte
        s0 = starts; p0 = stops;
        host_write(8'h60);
        wait_irq("R6 irq after repeated start");
        rd(1, v); chk("R6 repeated start status", v, 8'h10);
        chk("R6 repeated start without stop", {starts - s0, stops - p0}, {32'd1, 32'd0});

        // R7 stop
        p0 = stops;
        host_write(8'h50);
        wait_irq("R7 irq after stop");
        rd(1, v); chk("R7 stop status", v, 8'hE0);
        rd(0, v); chk("R7 stop request cleared", v, 8'h48);
        chk("R7 stop seen on bus", stops - p0, 1);
        chk("R7 lines released", {scl_oe, sda_oe}, 2'b00);

        // R11 stretch: high SCL untouched, low phase held
        tick(4);
        chk("R11 high SCL not pulled", scl_oe, 0);
        ext_scl = 1'b1;
        tick(4);
        ext_scl = 1'b0;
        tick(4);
        chk("R11 low phase held", {scl_oe, scl_line}, 2'b10);
        host_write(8'h40);
        rd(1, v); chk("R9 status back to idle", v, 8'hF8);
        tick(3);
        chk("R11 released after flag clears", {scl_oe, scl_line}, 2'b01);

        // R10 enable clear: flag without irq
        host_write(8'h20);
        for (int i = 0; i < 500; i++) begin
            rd(0, v);
            if (v[3]) break;
            tick(1);
        end
        chk("R10 flag set with enable clear", v, 8'h08);
        chk("R10 no irq when disabled", irq, 0);

        // R8 stop then start
        s0 = starts; p0 = stops;
        host_write(8'h70);
        wait_irq("R8 irq after stop+start");
        rd(1, v); chk("R8 status after stop+start", v, 8'h08);
        chk("R8 one stop and one start", {stops - p0, starts - s0}, {32'd1, 32'd1});
        stop_and_clear();

        // R4 busy bus: another master's START
        tick(5);
        ext_sda = 1'b1; tick(5);
        ext_scl = 1'b1; tick(5);
        s0 = starts;
        host_write(8'h60);
        tick(150);
        chk("R4 no drive on busy bus", sda_oe, 0);
        ext_scl = 1'b0; tick(5);
        ext_sda = 1'b0;
        wait_irq("R4 irq after queued start");
        rd(1, v); chk("R4 status after queued start", v, 8'h08);
        chk("R4 external and own start", starts - s0, 1);
        stop_and_clear();

        // R5 slave role
        tick(5);
        slave_addressed = 1'b1;
        host_write(8'h60);
        tick(TBUF * 5);
        chk("R5 no start while slave", sda_oe, 0);
        ext_scl = 1'b1; tick(3);
        ext_sda = 1'b1; tick(3);
        ext_scl = 1'b0; tick(3);
        ext_sda = 1'b0;
        slave_addressed = 1'b0;
        wait_irq("R5 irq after slave stop");
        rd(1, v); chk("R5 status after start", v, 8'h08);

        // random mix of master steps
        for (int k = 0; k < 8; k++) begin
            int op = int'($urandom % 3);
            tick(int'($urandom % 20));
            if (op == 1) begin
                host_write(8'h70);
                wait_irq("R8 random stop+start");
            end else begin
                host_write(8'h40);
                tick(int'($urandom % 10));
                pulse_byte();
                wait_irq("R12 random byte");
                if (op == 0) begin
                    rd(1, v); chk("R12 random byte status", v, 8'h28);
                    host_write(8'h60);
                    wait_irq("R6 random repeated start");
                end
            end
            rd(1, v); chk("R6 R8 R12 random final status", v, exp_code(op));
        end
        stop_and_clear();
        tick(10);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule